// File: doc/BRIEF.md
# Page Table Walk Unit

This unit turns a 31-bit virtual byte address into a 27-bit physical byte address. It looks the address up in a single-level page table that sits in physical memory. The page is 4 KiB, so the low 12 bits of the address are carried across unchanged. The upper 19 bits form the virtual page number. The unit adds that number, scaled to a word index, to a page-table base input, and fetches that one entry with a single memory read.

From the fetched entry the unit either builds the physical address or reports a page fault. When the entry is valid, the unit also keeps its status bits up to date by writing the entry back to the same memory address. Any access marks the entry as used, and a store also marks it as modified. The write-back is skipped when the entry already carries the right marks.

Only one translation is in flight at a time. A request is taken only while `busy` is low.

Top module: `pt_walker`

## Requirements
- R1: While reset is high and after it is released, `busy`, `resp_valid`, `mem_rd_en` and `mem_wr_en` are all 0.
- R2: An accepted request produces exactly one memory read, and that read is a single-cycle `mem_rd_en` pulse. Its address is (`ptbr` + 4 × `req_vaddr[30:12]`) modulo 2^27.
- R3: The entry uses bit 30 as valid, bits 14:0 as the physical page number, bit 29 as modified and bit 28 as used. For a valid entry (bit 30 = 1) the response has `resp_fault` = 0 and `resp_paddr` = {entry[14:0], `req_vaddr[11:0]`}. For example, virtual address 0x247C with an entry that maps to page 0x7FFF yields 0x7FFF47C.
- R4: For an entry with bit 30 = 0, the response has `resp_fault` = 1 and `resp_paddr` = 0, and no memory write takes place.
- R5: For a load to a valid entry whose used bit (bit 28) is 0, exactly one write goes to the entry's address. The written word is the fetched word with bit 28 set, and every other bit is unchanged. This includes bit 31 and the reserved bits 27:15, and bit 29 is not set.
- R6: For a store to a valid entry whose modified bit (bit 29) is 0, exactly one write goes to the entry's address. The written word is the fetched word with bits 29 and 28 set, and every other bit is unchanged.
- R7: No memory write takes place when the entry's status bits are already correct. That means the used bit is set on a load, or both the used and the modified bits are set on a store.
- R8: While `busy` is high, requests are ignored. They cause no extra memory read and no extra response.
- R9: Each accepted request gives exactly one response, and `resp_valid` is high for one cycle. On the cycle after the response, `busy` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Translation request strobe, taken only when busy is low |
| req_store | input | 1 | 1 if the access being translated is a store |
| req_vaddr | input | 31 | Virtual byte address |
| ptbr | input | 27 | Physical byte address of the page table |
| busy | output | 1 | A translation is in progress |
| resp_valid | output | 1 | One-cycle response strobe |
| resp_fault | output | 1 | Page fault: the entry was not valid |
| resp_paddr | output | 27 | Translated physical byte address |
| mem_rd_en | output | 1 | One-cycle read command for the entry |
| mem_wr_en | output | 1 | One-cycle write command for the entry write-back |
| mem_addr | output | 27 | Entry byte address for the read and for the write |
| mem_wdata | output | 32 | Updated entry word |
| mem_rdata | input | 32 | Entry word returned by memory |
| mem_rvalid | input | 1 | mem_rdata is valid in this cycle |

## Verification
The hardest case to reach from the ports is a request that arrives while a walk is still waiting for memory. The design must ignore it without issuing a second read or a second response. The bench reaches this case by stretching the memory model's read latency. It then drives stray requests with other addresses and the opposite access type during that wait, and counts reads and responses per walk. The write-back decision is driven through every combination of used bit, modified bit and access type. Entries carry nonzero reserved bits, so a write-back that clobbers neighbouring bits shows up in the written word.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;

  // Status bit positions inside a page-table entry word.
  localparam int ENT_VALID = 30;
  localparam int ENT_DIRTY = 29;
  localparam int ENT_USED  = 28;

  typedef enum logic [2:0] {
    WS_IDLE,
    WS_READ,
    WS_CHECK,
    WS_UPDATE,
    WS_DONE
  } walk_state_t;

endpackage

// File: rtl/pt_entry_addr.sv
module pt_entry_addr #(
  parameter int PA_W  = 27,
  parameter int VPN_W = 19
) (
  input  logic [PA_W-1:0]  base,
  input  logic [VPN_W-1:0] vpn,
  output logic [PA_W-1:0]  entry_addr
);

  localparam int SCALED_W = VPN_W + 2;

  logic [SCALED_W-1:0] scaled;

  always_comb begin
    scaled     = {vpn, 2'b00};
    entry_addr = base + PA_W'(scaled);
  end

endmodule

// File: rtl/pt_entry_eval.sv
module pt_entry_eval
  import pt_walker_pkg::*;
#(
  parameter int DW    = 32,
  parameter int PPN_W = 15,
  parameter int OFF_W = 12,
  parameter int PA_W  = 27
) (
  input  logic [DW-1:0]    entry,
  input  logic             is_store,
  input  logic [OFF_W-1:0] offset,
  output logic             fault,
  output logic             need_wb,
  output logic [DW-1:0]    new_entry,
  output logic [PA_W-1:0]  paddr
);

  logic valid_b, dirty_b, used_b;

  always_comb begin
    valid_b = entry[ENT_VALID];
    dirty_b = entry[ENT_DIRTY];
    used_b  = entry[ENT_USED];
    fault   = !valid_b;
    need_wb = valid_b && (!used_b || (is_store && !dirty_b));

    new_entry = entry;
    new_entry[ENT_USED] = 1'b1;
    if (is_store) new_entry[ENT_DIRTY] = 1'b1;

    paddr = valid_b ? {entry[PPN_W-1:0], offset} : '0;
  end

endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pt_walker_pkg::*;
#(
  parameter int VA_W  = 31,
  parameter int PA_W  = 27,
  parameter int OFF_W = 12,
  parameter int DW    = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req_valid,
  input  logic            req_store,
  input  logic [VA_W-1:0] req_vaddr,
  input  logic [PA_W-1:0] ptbr,
  output logic            busy,
  output logic            resp_valid,
  output logic            resp_fault,
  output logic [PA_W-1:0] resp_paddr,
  output logic            mem_rd_en,
  output logic            mem_wr_en,
  output logic [PA_W-1:0] mem_addr,
  output logic [DW-1:0]   mem_wdata,
  input  logic [DW-1:0]   mem_rdata,
  input  logic            mem_rvalid
);

  localparam int VPN_W = VA_W - OFF_W;
  localparam int PPN_W = PA_W - OFF_W;

  walk_state_t      state;
  logic [VA_W-1:0]  vaddr_q;
  logic             store_q;
  logic [DW-1:0]    entry_q;

  logic [PA_W-1:0]  entry_addr;
  logic             ev_fault;
  logic             ev_need_wb;
  logic [DW-1:0]    ev_new_entry;
  logic [PA_W-1:0]  ev_paddr;

  pt_entry_addr #(
    .PA_W (PA_W),
    .VPN_W(VPN_W)
  ) u_addr (
    .base      (ptbr),
    .vpn       (req_vaddr[VA_W-1:OFF_W]),
    .entry_addr(entry_addr)
  );

  pt_entry_eval #(
    .DW   (DW),
    .PPN_W(PPN_W),
    .OFF_W(OFF_W),
    .PA_W (PA_W)
  ) u_eval (
    .entry    (entry_q),
    .is_store (store_q),
    .offset   (vaddr_q[OFF_W-1:0]),
    .fault    (ev_fault),
    .need_wb  (ev_need_wb),
    .new_entry(ev_new_entry),
    .paddr    (ev_paddr)
  );

  assign busy = (state != WS_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= WS_IDLE;
      vaddr_q    <= '0;
      store_q    <= 1'b0;
      entry_q    <= '0;
      resp_valid <= 1'b0;
      resp_fault <= 1'b0;
      resp_paddr <= '0;
      mem_rd_en  <= 1'b0;
      mem_wr_en  <= 1'b0;
      mem_addr   <= '0;
      mem_wdata  <= '0;
    end else begin
      case (state)
        WS_IDLE: begin
          if (req_valid) begin
            vaddr_q   <= req_vaddr;
            store_q   <= req_store;
            mem_addr  <= entry_addr;
            mem_rd_en <= 1'b1;
            state     <= WS_READ;
          end
        end
        WS_READ: begin
          mem_rd_en <= 1'b0;
          if (mem_rvalid) begin
            entry_q <= mem_rdata;
            state   <= WS_CHECK;
          end
        end
        WS_CHECK: begin
          resp_fault <= ev_fault;
          resp_paddr <= ev_paddr;
          if (ev_need_wb) begin
            mem_wdata <= ev_new_entry;
            mem_wr_en <= 1'b1;
            state     <= WS_UPDATE;
          end else begin
            resp_valid <= 1'b1;
            state      <= WS_DONE;
          end
        end
        WS_UPDATE: begin
          mem_wr_en  <= 1'b0;
          resp_valid <= 1'b1;
          state      <= WS_DONE;
        end
        WS_DONE: begin
          resp_valid <= 1'b0;
          state      <= WS_IDLE;
        end
        default: state <= WS_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk #(
  parameter int PA_W = 27,
  parameter int DW   = 32
) (
  input logic            clk,
  input logic            rst,
  input logic            busy,
  input logic            resp_valid,
  input logic            resp_fault,
  input logic [PA_W-1:0] resp_paddr,
  input logic            mem_rd_en,
  input logic            mem_wr_en,
  input logic [DW-1:0]   mem_wdata
);

  // R2: a read command lasts one cycle
  p_rd_pulse_r2: assert property (@(posedge clk) disable iff (rst)
    mem_rd_en |=> !mem_rd_en);

  // R2, R8: a walk starts with its read, and only when leaving idle
  p_start_read_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_rd_en) |-> busy && !$past(busy));

  // R4: a fault response follows no write-back and carries a zero address
  p_fault_nowr_r4: assert property (@(posedge clk) disable iff (rst)
    resp_valid && resp_fault |-> !$past(mem_wr_en) && resp_paddr == '0);

  // R5: a written entry stays valid and is marked used
  p_wb_marks_r5: assert property (@(posedge clk) disable iff (rst)
    mem_wr_en |-> mem_wdata[30] && mem_wdata[28]);

  // R9: response is a single-cycle pulse and the unit then goes idle
  p_resp_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    resp_valid |=> !resp_valid && !busy);

  // R2: read and write never overlap
  p_rd_wr_excl_r2: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd_en && mem_wr_en));

endmodule

bind pt_walker pt_walker_chk #(.PA_W(PA_W), .DW(DW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .busy      (busy),
  .resp_valid(resp_valid),
  .resp_fault(resp_fault),
  .resp_paddr(resp_paddr),
  .mem_rd_en (mem_rd_en),
  .mem_wr_en (mem_wr_en),
  .mem_wdata (mem_wdata)
);

// File: tb/test_pt_walker.sv
module test_pt_walker;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_store = 1'b0;
  logic [30:0] req_vaddr = '0;
  logic [26:0] ptbr = '0;
  logic        busy, resp_valid, resp_fault;
  logic [26:0] resp_paddr;
  logic        mem_rd_en, mem_wr_en;
  logic [26:0] mem_addr;
  logic [31:0] mem_wdata;
  logic [31:0] mem_rdata;
  logic        mem_rvalid;

  always #4 clk = ~clk;

  pt_walker i_pt_walker (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_store(req_store),
    .req_vaddr(req_vaddr), .ptbr(ptbr), .busy(busy), .resp_valid(resp_valid),
    .resp_fault(resp_fault), .resp_paddr(resp_paddr), .mem_rd_en(mem_rd_en),
    .mem_wr_en(mem_wr_en), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_rvalid(mem_rvalid)
  );

  int total = 0;
  int bad = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  // Memory model with adjustable read latency
  logic [31:0] memw [int];
  int          lat = 2;
  logic        pend;
  int          cnt;
  logic [26:0] raddr;
  int          nreads = 0;
  int          nwrites = 0;
  logic [26:0] last_raddr, last_waddr;
  logic [31:0] last_wdata;

  always @(posedge clk) begin
    if (rst) begin
      pend <= 1'b0; mem_rvalid <= 1'b0; mem_rdata <= '0; cnt <= 0; raddr <= '0;
    end else begin
      mem_rvalid <= 1'b0;
      if (mem_rd_en) begin
        pend <= 1'b1; cnt <= lat; raddr <= mem_addr;
        nreads++; last_raddr = mem_addr;
      end else if (pend) begin
        if (cnt == 0) begin
          mem_rvalid <= 1'b1;
          mem_rdata  <= memw.exists(int'(raddr)) ? memw[int'(raddr)] : 32'h0;
          pend <= 1'b0;
        end else cnt <= cnt - 1;
      end
      if (mem_wr_en) begin
        memw[int'(mem_addr)] = mem_wdata;
        nwrites++; last_waddr = mem_addr; last_wdata = mem_wdata;
      end
    end
  end

  typedef struct packed {
    logic [26:0] addr;
    logic        fault;
    logic [26:0] paddr;
    logic        wr;
    logic [31:0] wdata;
  } exp_t;

  exp_t exp_q[$];
  int   resp_count = 0;
  int   rd_base = 0;
  int   wr_base = 0;

  // Monitor: compares each response with the head of the expected queue
  always @(negedge clk) begin
    if (!rst && resp_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R8", "unexpected response", 32'(resp_paddr), 32'h0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(nreads - rd_base == 1, "R2", "reads per walk", 32'(nreads - rd_base), 32'd1);
        check(last_raddr == e.addr, "R2", "entry address", 32'(last_raddr), 32'(e.addr));
        check(resp_fault == e.fault, e.fault ? "R4" : "R3", "fault flag", 32'(resp_fault), 32'(e.fault));
        check(resp_paddr == e.paddr, e.fault ? "R4" : "R3", "physical address", 32'(resp_paddr), 32'(e.paddr));
        check(nwrites - wr_base == (e.wr ? 1 : 0), e.wr ? "R5" : "R7", "write count",
              32'(nwrites - wr_base), 32'(e.wr));
        if (e.wr) begin
          check(last_wdata == e.wdata, e.wdata[29] ? "R6" : "R5", "written entry", last_wdata, e.wdata);
          check(last_waddr == e.addr, "R5", "write address", 32'(last_waddr), 32'(e.addr));
        end
      end
      rd_base = nreads;
      wr_base = nwrites;
      resp_count++;
    end
  end

  task automatic do_walk(input logic [30:0] va, input logic st, input logic [31:0] ent,
                         input int lat_i, input bit stray);
    exp_t e;
    logic [26:0] ea;
    int target;
    ea = ptbr + 27'({va[30:12], 2'b00});
    memw[int'(ea)] = ent;
    lat = lat_i;
    e.addr  = ea;
    e.fault = !ent[30];
    e.paddr = ent[30] ? {ent[14:0], va[11:0]} : 27'h0;
    e.wr    = ent[30] && (!ent[28] || (st && !ent[29]));
    e.wdata = ent | 32'h1000_0000 | (st ? 32'h2000_0000 : 32'h0);
    exp_q.push_back(e);
    target = resp_count + 1;
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = va; req_store = st;
    @(negedge clk);
    req_valid = 1'b0;
    if (stray) begin
      // R8: requests while busy must be ignored
      for (int k = 0; k < 3; k++) begin
        req_valid = 1'b1; req_vaddr = va ^ 31'h0123_4000; req_store = ~st;
        @(negedge clk);
      end
      req_valid = 1'b0;
    end
    while (resp_count < target) @(negedge clk);
    @(negedge clk);
    check(!resp_valid, "R9", "response pulse width", 32'(resp_valid), 32'h0);
    check(!busy, "R9", "busy after response", 32'(busy), 32'h0);
  endtask

  initial begin
    #(8 * 200000);
    check(1'b0, "R9", "watchdog expired", 32'h0, 32'h1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!busy && !resp_valid && !mem_rd_en && !mem_wr_en, "R1", "outputs in reset",
          {28'h0, busy, resp_valid, mem_rd_en, mem_wr_en}, 32'h0);
    rst = 1'b0;
    @(negedge clk);
    check(!busy && !resp_valid && !mem_rd_en && !mem_wr_en, "R1", "outputs after reset",
          {28'h0, busy, resp_valid, mem_rd_en, mem_wr_en}, 32'h0);

    ptbr = 27'h0010000;
    // R3 R5: the worked example, load to an unused entry
    do_walk(31'h0000247C, 1'b0, 32'h4000_7FFF, 2, 1'b0);
    // R7: same page again, used already set, load
    do_walk(31'h0000247C, 1'b0, 32'h5000_7FFF, 0, 1'b0);
    // R6: store to a used, clean entry
    do_walk(31'h00002000, 1'b1, 32'h5000_1234, 1, 1'b0);
    // R7: store to a used, dirty entry
    do_walk(31'h00002FFF, 1'b1, 32'h7000_1234, 3, 1'b0);
    // R4: invalid entry with status and reserved bits set
    do_walk(31'h0ABCD123, 1'b1, 32'hBFFF_FFFF, 2, 1'b0);
    // R6: store to an unused, clean entry
    do_walk(31'h00155ABC, 1'b1, 32'h4000_0042, 1, 1'b0);
    // R5: load preserves bit 31, the reserved bits and a clear dirty bit
    do_walk(31'h00031001, 1'b0, 32'hCAAA_8005, 2, 1'b0);
    // R2: base near the top, highest page, address wraps
    ptbr = 27'h7FFFFF0;
    do_walk(31'h7FFFFFFF, 1'b0, 32'h5000_7ABC, 1, 1'b0);
    // R8: stray requests during a long read
    ptbr = 27'h0200000;
    do_walk(31'h01234567, 1'b0, 32'h4000_0ACE, 4, 1'b1);
    do_walk(31'h00000000, 1'b1, 32'h7000_0001, 4, 1'b1);

    repeat (10) @(negedge clk);
    check(exp_q.size() == 0, "R9", "outstanding expected responses", 32'(exp_q.size()), 32'h0);
    check(resp_count == 10, "R8", "total responses", 32'(resp_count), 32'd10);
    check(nreads == 10, "R8", "total reads", 32'(nreads), 32'd10);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule